// File: doc/BRIEF.md
# SPI Slave with Select Synchronization

This block receives and sends bytes as the slave of a serial peripheral link. The external master supplies the serial clock. All serial inputs (clock, select and data in) are brought into the system clock domain through synchronizer chains. Bits move only on detected edges of the external clock. The system clock must run at least four times faster than the serial clock.

On the parallel side, a transmit buffer write port supplies the next outgoing byte. Each completed incoming byte lands in a receive register, and a completion flag is raised. An overflow flag is raised when a byte completes before the previous one was read.

A 4-bit mode code picks one of three behaviours:
- A select-controlled slave, in which the active-low select pin frames every byte. Raising select aborts a byte at any point.
- A free-running slave that ignores select.
- An inactive state.

Top module: `spi_sel_slave`

## Requirements
- R1: Data moves only on detected serial-clock edges. A byte completes on the eighth sampling edge, and not before. Both directions send the most significant bit first.
- R2: On completion, the assembled byte is copied to `rx_data` and `irq` is set. `irq` stays set until `irq_clr` is pulsed.
- R3: Mode code 4'b0101 runs the slave without select. Transfers proceed and `sdo_oe` is high whenever `en` is high, whatever the level of `ss_n`.
- R4: Any mode code other than 4'b0100 or 4'b0101 leaves the block inactive. `sdo_oe` stays low and no byte completes.
- R5: In mode 4'b0100 with `en` high, `sdo_oe` is high while `ss_n` is low. It drops in the same cycle that `ss_n` goes high, including partway through a byte.
- R6: The bit counter returns to zero in two cases: when `ss_n` is high in mode 4'b0100, or when `en` is low. The next byte is then framed from its first bit, and a partial byte is never reported.
- R7: The leading edge is the rising edge when `cpol`=0 and the falling edge when `cpol`=1. With `cpha`=0, `sdi` is sampled on the leading edge and `sdo` changes on the trailing edge. With `cpha`=1, `sdo` changes on the leading edge and `sdi` is sampled on the trailing edge.
- R8: `bad_cfg` is high exactly when `en` and `cpha` are high and the mode code is 4'b0101, which is an unsupported combination.
- R9: The first bit presented on `sdo` is bit 7 of the last value written through `tx_wr`. A value written between bytes is used for the next byte.
- R10: A byte that completes while the previous one is unread sets `ovf`. A byte is unread from its completion until `rx_rd` is pulsed. In that case `rx_data` keeps the earlier byte. `ovf` stays set until `ovf_clr` is pulsed.
- R11: After reset, `sdo_oe`, `irq`, `ovf` and `bad_cfg` are low and `rx_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Block enable; low clears the bit counter |
| mode | input | 4 | Slave mode code |
| cpol | input | 1 | Idle level of the serial clock |
| cpha | input | 1 | Edge select for sampling and shifting |
| sck | input | 1 | Serial clock from the master |
| ss_n | input | 1 | Active-low slave select |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Drive enable for the serial data out pin |
| tx_wr | input | 1 | Write strobe for the transmit buffer |
| tx_data | input | DATA_W | Transmit buffer write data |
| rx_rd | input | 1 | Read strobe that marks the received byte as taken |
| rx_data | output | DATA_W | Last received byte |
| irq | output | 1 | Byte completion flag |
| irq_clr | input | 1 | Clears the completion flag |
| ovf | output | 1 | Receive overflow flag |
| ovf_clr | input | 1 | Clears the overflow flag |
| bad_cfg | output | 1 | Unsupported mode combination indicator |

## Verification
The bench builds the block with its defaults: an 8-bit word, two synchronizer stages and the keep-on-overflow policy. The serial half period is eight system clocks. At that rate the full synchronizer and edge-detect latency fits well inside each half period, so all four clock modes can be swept. The 8-bit word puts the byte boundary within reach of the split-transfer case that stops after seven bits. The keep policy makes the retained first byte observable on `rx_data` after an overflow.

// File: rtl/spi_sel_pkg.sv
package spi_sel_pkg;

   localparam int MODE_W = 4;
   localparam logic [MODE_W-1:0] MODE_SEL  = 4'b0100;
   localparam logic [MODE_W-1:0] MODE_FREE = 4'b0101;

   typedef enum logic [1:0] {
      SLV_OFF    = 2'd0,
      SLV_SELECT = 2'd1,
      SLV_FREE   = 2'd2
   } slv_kind_e;

   function automatic slv_kind_e decode_mode(input logic [MODE_W-1:0] code);
      slv_kind_e kind;
      case (code)
         MODE_SEL:  kind = SLV_SELECT;
         MODE_FREE: kind = SLV_FREE;
         default:   kind = SLV_OFF;
      endcase
      return kind;
   endfunction

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
   parameter int WIDTH = 1,
   parameter int STAGES = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("spi_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] chain [STAGES];

   genvar s;
   generate
      for (s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= RST_VAL;
               else        chain[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= RST_VAL;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];

endmodule

// File: rtl/spi_edge_ctrl.sv
module spi_edge_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic sck_s,
   input  logic cpol,
   input  logic cpha,
   output logic sample_ev,
   output logic shift_ev
);

   logic sck_d;
   logic rise, fall, lead, trail;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_d <= 1'b0;
      else        sck_d <= sck_s;
   end

   assign rise  = sck_s & ~sck_d;
   assign fall  = ~sck_s & sck_d;
   // leading edge leaves the idle level
   assign lead  = cpol ? fall : rise;
   assign trail = cpol ? rise : fall;

   assign sample_ev = cpha ? trail : lead;
   assign shift_ev  = cpha ? lead  : trail;

endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
   parameter int DATA_W = 8,
   localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              sample_ev,
   input  logic              shift_ev,
   input  logic              sdi_s,
   input  logic [DATA_W-1:0] tx_buf,
   output logic              sdo_bit,
   output logic              byte_done,
   output logic [DATA_W-1:0] rx_word,
   output logic [CNT_W-1:0]  cnt_o
);

   localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

   logic [CNT_W-1:0]  cnt;
   logic [DATA_W-1:0] rx_sr;
   logic [DATA_W-1:0] tx_sr;
   logic              at_last;
   logic              at_first;

   assign at_last  = (cnt == LAST);
   assign at_first = (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         rx_sr <= '0;
      end else if (clr) begin
         cnt   <= '0;
         rx_sr <= '0;
      end else if (sample_ev) begin
         rx_sr <= {rx_sr[DATA_W-2:0], sdi_s};
         cnt   <= at_last ? '0 : cnt + 1'b1;
      end
   end

   // between bytes the outgoing register follows the buffer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          tx_sr <= '0;
      else if (clr)        tx_sr <= tx_buf;
      else if (at_first)   tx_sr <= tx_buf;
      else if (shift_ev)   tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
   end

   assign sdo_bit   = tx_sr[DATA_W-1];
   assign byte_done = sample_ev && at_last && !clr;
   assign rx_word   = {rx_sr[DATA_W-2:0], sdi_s};
   assign cnt_o     = cnt;

endmodule

// File: rtl/spi_sel_slave.sv
module spi_sel_slave
   import spi_sel_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int KEEP_ON_OVF = 1,
   localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [3:0]        mode,
   input  logic              cpol,
   input  logic              cpha,
   input  logic              sck,
   input  logic              ss_n,
   input  logic              sdi,
   output logic              sdo,
   output logic              sdo_oe,
   input  logic              tx_wr,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              rx_rd,
   output logic [DATA_W-1:0] rx_data,
   output logic              irq,
   input  logic              irq_clr,
   output logic              ovf,
   input  logic              ovf_clr,
   output logic              bad_cfg
);

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("spi_sel_slave: DATA_W must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("spi_sel_slave: SYNC_STAGES must be at least 2");
      end
      if (KEEP_ON_OVF != 0 && KEEP_ON_OVF != 1) begin : g_bad_policy
         $error("spi_sel_slave: KEEP_ON_OVF must be 0 or 1");
      end
   endgenerate

   logic [2:0] pins_raw, pins_s;
   logic       sck_s, ss_s, sdi_s;

   assign pins_raw = {sdi, ss_n, sck};

   spi_sync #(
      .WIDTH   (3),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (3'b010)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pins_raw),
      .q     (pins_s)
   );

   assign sck_s = pins_s[0];
   assign ss_s  = pins_s[1];
   assign sdi_s = pins_s[2];

   slv_kind_e kind;
   logic      active, sel_ctl, run, clr;

   assign kind    = decode_mode(mode);
   assign active  = en && (kind != SLV_OFF);
   assign sel_ctl = (kind == SLV_SELECT);
   assign run     = active && (!sel_ctl || !ss_s);
   assign clr     = !run;

   // output enable follows the raw select pin so release is immediate
   assign sdo_oe  = active && (!sel_ctl || !ss_n);
   assign bad_cfg = en && cpha && (kind == SLV_FREE);

   logic sample_ev, shift_ev;

   spi_edge_ctrl u_edge (
      .clk       (clk),
      .rst_n     (rst_n),
      .sck_s     (sck_s),
      .cpol      (cpol),
      .cpha      (cpha),
      .sample_ev (sample_ev),
      .shift_ev  (shift_ev)
   );

   logic [DATA_W-1:0] tx_buf;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     tx_buf <= '0;
      else if (tx_wr) tx_buf <= tx_data;
   end

   logic              byte_done;
   logic [DATA_W-1:0] rx_word;
   logic [CNT_W-1:0]  bit_cnt;
   logic              sdo_bit;

   spi_shift_core #(
      .DATA_W (DATA_W)
   ) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr),
      .sample_ev (sample_ev),
      .shift_ev  (shift_ev),
      .sdi_s     (sdi_s),
      .tx_buf    (tx_buf),
      .sdo_bit   (sdo_bit),
      .byte_done (byte_done),
      .rx_word   (rx_word),
      .cnt_o     (bit_cnt)
   );

   assign sdo = sdo_bit;

   logic rx_full;
   logic overrun;
   logic rx_load;

   assign overrun = byte_done && rx_full && !rx_rd;

   generate
      if (KEEP_ON_OVF != 0) begin : g_keep
         assign rx_load = byte_done && !overrun;
      end else begin : g_replace
         assign rx_load = byte_done;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rx_data <= '0;
      else if (rx_load) rx_data <= rx_word;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         rx_full <= 1'b0;
      else if (byte_done) rx_full <= 1'b1;
      else if (rx_rd)     rx_full <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         irq <= 1'b0;
      else if (byte_done) irq <= 1'b1;
      else if (irq_clr)   irq <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ovf <= 1'b0;
      else if (overrun) ovf <= 1'b1;
      else if (ovf_clr) ovf <= 1'b0;
   end

endmodule

// File: rtl/spi_sel_slave_chk.sv
module spi_sel_slave_chk #(
   parameter int DATA_W = 8,
   parameter int KEEP_ON_OVF = 1,
   localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              en,
   input logic [3:0]        mode,
   input logic              cpha,
   input logic              ss_n,
   input logic              ss_s,
   input logic              sdo_oe,
   input logic              irq,
   input logic              ovf,
   input logic              rx_full,
   input logic [DATA_W-1:0] rx_data,
   input logic              bad_cfg,
   input logic [CNT_W-1:0]  bit_cnt
);

   AST_SEL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) // R5
      (en && mode == 4'b0100 && ss_n) |-> !sdo_oe);

   AST_FREE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n) // R3
      (en && mode == 4'b0101) |-> sdo_oe);

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) // R4
      (mode != 4'b0100 && mode != 4'b0101) |-> !sdo_oe);

   AST_SEL_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) // R6
      (en && mode == 4'b0100 && ss_s) |=> (bit_cnt == '0));

   AST_DIS_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) // R6
      !en |=> (bit_cnt == '0));

   AST_IRQ_WITH_DATA: assert property (@(posedge clk) disable iff (!rst_n) // R2
      $rose(irq) |-> rx_full);

   AST_OVF_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n) // R10
      $rose(ovf) |-> $past(rx_full));

   AST_BAD_CFG: assert property (@(posedge clk) disable iff (!rst_n) // R8
      (en && cpha && mode == 4'b0101) |-> bad_cfg);

   generate
      if (KEEP_ON_OVF != 0) begin : g_keep_chk
         AST_OVF_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n) // R10
            $rose(ovf) |-> $stable(rx_data));
      end
   endgenerate

endmodule

bind spi_sel_slave spi_sel_slave_chk #(
   .DATA_W      (DATA_W),
   .KEEP_ON_OVF (KEEP_ON_OVF)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .en      (en),
   .mode    (mode),
   .cpha    (cpha),
   .ss_n    (ss_n),
   .ss_s    (ss_s),
   .sdo_oe  (sdo_oe),
   .irq     (irq),
   .ovf     (ovf),
   .rx_full (rx_full),
   .rx_data (rx_data),
   .bad_cfg (bad_cfg),
   .bit_cnt (bit_cnt)
);

// File: tb/spi_sel_slave_test.sv
`timescale 1ns/1ps
module spi_sel_slave_test;

   localparam int H = 8;

   logic       clk = 1'b0;
   logic       rst_n, en, cpol, cpha, sck, ss_n, sdi;
   logic [3:0] mode;
   logic       sdo, sdo_oe, tx_wr, rx_rd, irq, irq_clr, ovf, ovf_clr, bad_cfg;
   logic [7:0] tx_data, rx_data;

   int  checks = 0;
   int  errors = 0;
   bit  mon_en = 1'b1;
   bit  finished = 1'b0;
   logic [7:0] exp_q[$];

   always #10 clk = ~clk;

   spi_sel_slave uut (
      .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .cpol(cpol), .cpha(cpha),
      .sck(sck), .ss_n(ss_n), .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe),
      .tx_wr(tx_wr), .tx_data(tx_data), .rx_rd(rx_rd), .rx_data(rx_data),
      .irq(irq), .irq_clr(irq_clr), .ovf(ovf), .ovf_clr(ovf_clr), .bad_cfg(bad_cfg)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic configure(input logic [3:0] m, input logic pol, input logic pha);
      en = 1'b0; mode = m; cpol = pol; cpha = pha; sck = pol; ss_n = 1'b1;
      repeat (6) @(negedge clk);
      en = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   task automatic load_tx(input logic [7:0] v);
      @(negedge clk); tx_wr = 1'b1; tx_data = v;
      @(negedge clk); tx_wr = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic select_on();
      ss_n = 1'b0;
      repeat (6) @(negedge clk);
   endtask

   task automatic shift_bits(input logic [7:0] mo, input int hi, input int lo,
                             inout logic [7:0] mi);
      for (int i = hi; i >= lo; i--) begin
         if (!cpha) begin
            sdi = mo[i];
            repeat (H) @(negedge clk);
            mi[i] = sdo; sck = ~cpol;
            repeat (H) @(negedge clk);
            sck = cpol;
         end else begin
            sck = ~cpol; sdi = mo[i];
            repeat (H) @(negedge clk);
            mi[i] = sdo; sck = cpol;
            repeat (H) @(negedge clk);
         end
      end
      repeat (H) @(negedge clk);
   endtask

   // driver: queue the expected received byte, then clock it through
   task automatic full_byte(input logic [7:0] mo, input logic [7:0] exp_mi,
                            input string req);
      logic [7:0] mi = '0;
      exp_q.push_back(mo);
      shift_bits(mo, 7, 0, mi);
      chk(mi === exp_mi, req, mi, exp_mi);
      repeat (8) @(negedge clk);
   endtask

   // monitor: compare each completed byte with the scoreboard head
   initial begin
      forever begin
         @(negedge clk);
         if (mon_en && rst_n === 1'b1 && irq === 1'b1) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R2 unexpected byte", rx_data, 0);
            end else begin
               logic [7:0] e;
               e = exp_q.pop_front();
               chk(rx_data === e, "R2 received byte", rx_data, e);
            end
            rx_rd = 1'b1; irq_clr = 1'b1;
            @(negedge clk);
            rx_rd = 1'b0; irq_clr = 1'b0;
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] mi;
      rst_n = 1'b0; en = 1'b0; mode = 4'b0000; cpol = 1'b0; cpha = 1'b0;
      sck = 1'b0; ss_n = 1'b1; sdi = 1'b0; tx_wr = 1'b0; tx_data = '0;
      rx_rd = 1'b0; irq_clr = 1'b0; ovf_clr = 1'b0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk(sdo_oe === 1'b0, "R11 sdo_oe", sdo_oe, 0);
      chk(irq === 1'b0, "R11 irq", irq, 0);
      chk(ovf === 1'b0, "R11 ovf", ovf, 0);
      chk(bad_cfg === 1'b0, "R11 bad_cfg", bad_cfg, 0);
      chk(rx_data === 8'h00, "R11 rx_data", rx_data, 0);

      // R7 mode sweep with select control, R1 and R9 MSB first
      configure(4'b0100, 1'b0, 1'b0);
      load_tx(8'h3C);
      select_on();
      chk(sdo_oe === 1'b1, "R5 driven while selected", sdo_oe, 1);
      full_byte(8'hA5, 8'h3C, "R1 mode0 sdo");
      configure(4'b0100, 1'b0, 1'b1);
      load_tx(8'h96); select_on();
      full_byte(8'h5A, 8'h96, "R7 mode1 sdo");
      configure(4'b0100, 1'b1, 1'b0);
      load_tx(8'hC3); select_on();
      full_byte(8'h81, 8'hC3, "R7 mode2 sdo");
      configure(4'b0100, 1'b1, 1'b1);
      load_tx(8'h7E); select_on();
      full_byte(8'hE7, 8'h7E, "R9 mode3 sdo");
      load_tx(8'h11);
      full_byte(8'h22, 8'h11, "R9 next byte buffer");

      // R1 no completion after seven bits
      configure(4'b0100, 1'b0, 1'b0);
      load_tx(8'hF0); select_on();
      mi = '0;
      exp_q.push_back(8'h99);
      shift_bits(8'h99, 7, 1, mi);
      repeat (20) @(negedge clk);
      chk(irq === 1'b0, "R1 seven bits no irq", irq, 0);
      shift_bits(8'h99, 0, 0, mi);
      chk(mi === 8'hF0, "R1 split byte sdo", mi, 8'hF0);
      repeat (8) @(negedge clk);

      // R5 and R6 abort through select
      load_tx(8'hAA);
      mi = '0;
      shift_bits(8'hFF, 7, 5, mi);
      @(negedge clk); ss_n = 1'b1;
      #1;
      chk(sdo_oe === 1'b0, "R5 release mid byte", sdo_oe, 0);
      repeat (10) @(negedge clk);
      chk(irq === 1'b0, "R6 partial not reported", irq, 0);
      select_on();
      full_byte(8'h4D, 8'hAA, "R6 reframed after select");

      // R3 free mode ignores select
      configure(4'b0101, 1'b0, 1'b0);
      chk(sdo_oe === 1'b1, "R3 driven without select", sdo_oe, 1);
      load_tx(8'h6B);
      full_byte(8'hB6, 8'h6B, "R3 free mode transfer");

      // R6 abort through enable
      mi = '0;
      shift_bits(8'h00, 7, 4, mi);
      en = 1'b0;
      repeat (6) @(negedge clk);
      en = 1'b1;
      repeat (4) @(negedge clk);
      full_byte(8'h39, 8'h6B, "R6 reframed after disable");

      // R8 unsupported combination
      cpha = 1'b1;
      @(negedge clk);
      chk(bad_cfg === 1'b1, "R8 free with edge select", bad_cfg, 1);
      cpha = 1'b0;
      @(negedge clk);
      chk(bad_cfg === 1'b0, "R8 free without edge select", bad_cfg, 0);
      configure(4'b0100, 1'b0, 1'b1);
      chk(bad_cfg === 1'b0, "R8 select with edge select", bad_cfg, 0);

      // R4 inactive mode code
      configure(4'b0000, 1'b0, 1'b0);
      select_on();
      chk(sdo_oe === 1'b0, "R4 not driven", sdo_oe, 0);
      mi = '0;
      shift_bits(8'hC5, 7, 0, mi);
      repeat (10) @(negedge clk);
      chk(irq === 1'b0, "R4 no byte", irq, 0);

      // R2 flag hold and R10 overflow
      configure(4'b0100, 1'b0, 1'b0);
      select_on();
      mon_en = 1'b0;
      mi = '0;
      shift_bits(8'h12, 7, 0, mi);
      repeat (10) @(negedge clk);
      chk(irq === 1'b1, "R2 flag set", irq, 1);
      chk(rx_data === 8'h12, "R2 byte stored", rx_data, 8'h12);
      repeat (50) @(negedge clk);
      chk(irq === 1'b1, "R2 flag held", irq, 1);
      shift_bits(8'h34, 7, 0, mi);
      repeat (10) @(negedge clk);
      chk(ovf === 1'b1, "R10 overflow set", ovf, 1);
      chk(rx_data === 8'h12, "R10 earlier byte kept", rx_data, 8'h12);
      @(negedge clk); ovf_clr = 1'b1; rx_rd = 1'b1; irq_clr = 1'b1;
      @(negedge clk); ovf_clr = 1'b0; rx_rd = 1'b0; irq_clr = 1'b0;
      @(negedge clk);
      chk(ovf === 1'b0, "R10 overflow cleared", ovf, 0);
      chk(irq === 1'b0, "R2 flag cleared", irq, 0);
      mon_en = 1'b1;

      chk(exp_q.size() == 0, "R2 all bytes seen", exp_q.size(), 0);
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule